// File: doc/BRIEF.md
# Bus Monitor Word Tagger

The tagger sits behind the word decoders of a dual-channel MIL-STD-1553 monitor. Each decoder hands it a finished 16-bit word with a strobe, a flag for command/status sync and a flag for a bad word. The tagger turns each word into a pair of entries in a shared memory. The first entry is the raw word. The second is a tag word built from these fields: a constant marker bit, the channel, the sync type, the invalid flag, a contiguous-data bit and the idle time since the previous word. Idle time is counted in half-microsecond units. After every pair, the block stores the next free address at a fixed pointer location so that host software can find the end of the log.

A host start pulse arms the block. It stays armed until a host reset pulse. The reset pulse also returns the fill address to the bottom of memory. Words that arrive while the block is not armed are dropped. Each pair costs three write cycles: data, tag, then pointer. If both channels deliver a word in the same cycle, channel A takes the first three-cycle slot and channel B takes the next one.

Top module: `mon_tagger`

## Requirements
- R1: For every accepted word, the block writes the raw word at the fill address. In the next cycle it writes the tag at the fill address plus one.
- R2: Tag bit 15 is always 1 and tag bits 11:9 are always 0.
- R3: Tag bit 14 is the channel (0 = A, 1 = B), tag bit 13 is 1 for command/status sync, and tag bit 12 is 1 for an invalid word.
- R4: Tag bits 7:0 give the number of `gap_tick` pulses seen since the previous accepted word, or since start. The count saturates at 255.
- R5: Tag bit 8 is 1 when the gap count is below `CONTIG_TH` (default 4). Otherwise it is 0.
- R6: In the cycle after the tag write, the block writes the next free fill address to `PTR_ADDR` (default 0x0100).
- R7: The fill address is 0x0000 after a reset command. It advances by 2 per pair and returns to 0x0000 in place of reaching `PTR_ADDR`.
- R8: Before a start pulse, and after a reset pulse, the block makes no writes and drops words. A reset pulse abandons any pair still in flight.
- R9: When both channels present a word in the same cycle, the block writes channel A's pair first. Channel B's data write follows exactly 3 cycles after A's data write.
- R10: When a word arrives in the same cycle as a `gap_tick`, that tick counts toward neither the word's gap nor the next word's gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_cmd | input | 1 | Host start pulse |
| reset_cmd | input | 1 | Host reset pulse; takes priority over start |
| gap_tick | input | 1 | Enable pulse, once every 0.5 µs |
| a_vld | input | 1 | Channel A word strobe |
| a_word | input | 16 | Channel A received word |
| a_cmd | input | 1 | Channel A command/status sync |
| a_bad | input | 1 | Channel A word invalid |
| b_vld | input | 1 | Channel B word strobe |
| b_word | input | 16 | Channel B received word |
| b_cmd | input | 1 | Channel B command/status sync |
| b_bad | input | 1 | Channel B word invalid |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| running | output | 1 | Block is armed |

## Verification
Two events can land on the same clock edge: a word arrival that samples and clears the gap timer, and a half-microsecond tick that would advance the timer. The bench drives a word strobe and a `gap_tick` in the same cycle after a known number of ticks. It then checks two tag values: the gap recorded for that word must exclude the coincident tick, and the gap recorded for the following word must count only the ticks issued after it. The bench also raises both channel strobes together and checks the order and cycle spacing of the two pairs in the write log.

// File: rtl/mon_pkg.sv
package mon_pkg;
    localparam int WORD_W = 16;
    localparam int GAP_W  = 8;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DATA = 2'd1,
        S_TAG  = 2'd2,
        S_PTR  = 2'd3
    } wr_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              cmd;
        logic              bad;
        logic [GAP_W-1:0]  gap;
    } word_rec_t;
endpackage

// File: rtl/mon_gap_timer.sv
module mon_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic             mark,
    output logic [GAP_W-1:0] gap_o
);
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic [GAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || mark) begin
            cnt_d = '0;
        end else if (run && tick && cnt_q != GAP_MAX) begin
            cnt_d = cnt_q + GAP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign gap_o = cnt_q;

    // R4: a saturated count holds until a word or clear restarts it
    p_gap_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == GAP_MAX && !clr && !mark) |=> cnt_q == GAP_MAX);

    // R10: an arrival restarts the count at zero, coincident tick or not
    p_gap_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mark |=> cnt_q == '0);
endmodule

// File: rtl/mon_chan_hold.sv
module mon_chan_hold
    import mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      load,
    input  word_rec_t rec_i,
    input  logic      pop,
    output logic      pend_o,
    output word_rec_t rec_o
);
    logic      pend_d, pend_q;
    word_rec_t rec_d, rec_q;

    always_comb begin
        pend_d = pend_q;
        rec_d  = rec_q;
        if (clr) begin
            pend_d = 1'b0;
        end else if (load) begin
            pend_d = 1'b1;
            rec_d  = rec_i;
        end else if (pop) begin
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            rec_q  <= '0;
        end else begin
            pend_q <= pend_d;
            rec_q  <= rec_d;
        end
    end

    assign pend_o = pend_q;
    assign rec_o  = rec_q;

    // R9: a waiting word is kept until it is served or cleared
    p_hold_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !pop && !clr) |=> pend_q);
endmodule

// File: rtl/mon_tagger.sv
module mon_tagger
    import mon_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PTR_ADDR  = 16'h0100,
    parameter logic [GAP_W-1:0]  CONTIG_TH = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic              reset_cmd,
    input  logic              gap_tick,
    input  logic              a_vld,
    input  logic [WORD_W-1:0] a_word,
    input  logic              a_cmd,
    input  logic              a_bad,
    input  logic              b_vld,
    input  logic [WORD_W-1:0] b_word,
    input  logic              b_cmd,
    input  logic              b_bad,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              running
);
    localparam int N_CH = 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

    typedef struct packed {
        wr_state_e         st;
        logic              run;
        logic [ADDR_W-1:0] wp;
        logic              ch;
        word_rec_t         cur;
    } tag_state_t;

    tag_state_t        st_d, st_q;
    logic [GAP_W-1:0]  gap_cnt;
    logic [N_CH-1:0]   vld_w, load_w, pend_w, pop_w;
    word_rec_t         rec_in [N_CH];
    word_rec_t         rec_hold [N_CH];
    logic [ADDR_W-1:0] nxt_wp;
    logic [WORD_W-1:0] tag_w;
    logic              arrive;

    assign vld_w     = {b_vld, a_vld};
    assign rec_in[0] = '{data: a_word, cmd: a_cmd, bad: a_bad, gap: gap_cnt};
    assign rec_in[1] = '{data: b_word, cmd: b_cmd, bad: b_bad, gap: gap_cnt};
    assign load_w    = st_q.run ? vld_w : '0;
    assign arrive    = |load_w;

    mon_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reset_cmd | (start_cmd & ~st_q.run)),
        .run   (st_q.run),
        .tick  (gap_tick),
        .mark  (arrive),
        .gap_o (gap_cnt)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        mon_chan_hold u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (reset_cmd),
            .load   (load_w[c]),
            .rec_i  (rec_in[c]),
            .pop    (pop_w[c]),
            .pend_o (pend_w[c]),
            .rec_o  (rec_hold[c])
        );
    end

    always_comb begin
        st_d   = st_q;
        pop_w  = '0;
        nxt_wp = (st_q.wp >= PTR_ADDR - STEP) ? '0 : st_q.wp + STEP;
        case (st_q.st)
            S_DATA:  st_d.st = S_TAG;
            S_TAG: begin
                st_d.st = S_PTR;
                st_d.wp = nxt_wp;
            end
            default: st_d.st = S_IDLE;
        endcase
        if (st_q.run && (st_q.st == S_IDLE || st_q.st == S_PTR)) begin
            if (pend_w[0]) begin
                st_d.st  = S_DATA;
                st_d.ch  = 1'b0;
                st_d.cur = rec_hold[0];
                pop_w[0] = 1'b1;
            end else if (pend_w[1]) begin
                st_d.st  = S_DATA;
                st_d.ch  = 1'b1;
                st_d.cur = rec_hold[1];
                pop_w[1] = 1'b1;
            end
        end
        if (reset_cmd) begin
            st_d.run = 1'b0;
            st_d.st  = S_IDLE;
            st_d.wp  = '0;
        end else if (start_cmd) begin
            st_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        tag_w = {1'b1, st_q.ch, st_q.cur.cmd, st_q.cur.bad, 3'b000,
                 (st_q.cur.gap < CONTIG_TH), st_q.cur.gap};
        mem_we = (st_q.st != S_IDLE);
        case (st_q.st)
            S_DATA: begin
                mem_addr  = st_q.wp;
                mem_wdata = st_q.cur.data;
            end
            S_TAG: begin
                mem_addr  = st_q.wp + ADDR_W'(1);
                mem_wdata = tag_w;
            end
            S_PTR: begin
                mem_addr  = PTR_ADDR;
                mem_wdata = WORD_W'(st_q.wp);
            end
            default: begin
                mem_addr  = '0;
                mem_wdata = '0;
            end
        endcase
    end

    assign running = st_q.run;

    // R1: tag write lands one address above the data, one cycle later
    p_tag_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == S_DATA && !reset_cmd) |=>
            (mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R2: marker bit set and spare bits clear in every tag
    p_tag_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == S_TAG) |-> (mem_wdata[15] && mem_wdata[11:9] == 3'b000));

    // R6: pointer write follows the tag and holds an in-range address
    p_ptr_after_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == S_TAG && !reset_cmd) |=>
            (mem_we && mem_addr == PTR_ADDR && mem_wdata < WORD_W'(PTR_ADDR)));

    // R7: log writes never reach the pointer location
    p_log_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && st_q.st != S_PTR) |-> mem_addr < PTR_ADDR);

    // R8: no writes while disarmed
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> !mem_we);

    // R9: channel A wins a slot when both channels wait
    p_a_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.st == S_IDLE && pend_w == 2'b11 && !reset_cmd) |=>
            (st_q.st == S_DATA && !st_q.ch));
endmodule

// File: tb/sim_mon_tagger.sv
module sim_mon_tagger;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, start_cmd, reset_cmd, gap_tick;
    logic        a_vld, a_cmd, a_bad, b_vld, b_cmd, b_bad;
    logic [15:0] a_word, b_word;
    logic        mem_we, running;
    logic [15:0] mem_addr, mem_wdata;

    mon_tagger u0 (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .reset_cmd(reset_cmd),
        .gap_tick(gap_tick),
        .a_vld(a_vld), .a_word(a_word), .a_cmd(a_cmd), .a_bad(a_bad),
        .b_vld(b_vld), .b_word(b_word), .b_cmd(b_cmd), .b_bad(b_bad),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .running(running)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    int exp_gap = 0;
    logic [15:0] exp_wp = 16'h0000;

    logic [15:0] log_a[$];
    logic [15:0] log_d[$];
    int          log_c[$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mem_we) begin
            log_a.push_back(mem_addr);
            log_d.push_back(mem_wdata);
            log_c.push_back(cyc);
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic clear_log();
        log_a.delete();
        log_d.delete();
        log_c.delete();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            gap_tick = 1'b1;
            @(negedge clk);
            gap_tick = 1'b0;
            if (exp_gap < 255) exp_gap++;
        end
    endtask

    task automatic send(input logic ch, input logic [15:0] d, input logic c, input logic x);
        if (ch) begin b_vld = 1; b_word = d; b_cmd = c; b_bad = x; end
        else    begin a_vld = 1; a_word = d; a_cmd = c; a_bad = x; end
        @(negedge clk);
        a_vld = 0; b_vld = 0;
    endtask

    function automatic logic [15:0] mk_tag(input logic ch, input logic c, input logic x, input int g);
        logic [7:0] g8;
        g8 = 8'(g);
        return {1'b1, ch, c, x, 3'b000, (g < 4), g8};
    endfunction

    function automatic logic [15:0] adv(input logic [15:0] w);
        return (w + 16'd2 >= 16'h0100) ? 16'h0000 : w + 16'd2;
    endfunction

    task automatic check_pair(input string r, input int k, input logic ch,
                              input logic [15:0] d, input logic c, input logic x, input int g);
        if (log_a.size() < k + 3) begin
            chk({r, " R1 pair present"}, log_a.size(), k + 3);
            return;
        end
        chk({r, " R1/R7 data addr"}, log_a[k], exp_wp);
        chk({r, " R1 data"}, log_d[k], d);
        chk({r, " R1 tag addr"}, log_a[k+1], exp_wp + 16'd1);
        chk({r, " R2/R3/R4/R5 tag"}, log_d[k+1], mk_tag(ch, c, x, g));
        chk({r, " R1 tag cycle"}, log_c[k+1] - log_c[k], 1);
        exp_wp = adv(exp_wp);
        chk({r, " R6 ptr addr"}, log_a[k+2], 16'h0100);
        chk({r, " R6/R7 ptr value"}, log_d[k+2], exp_wp);
    endtask

    task automatic one_word(input string r, input int g, input logic ch,
                            input logic [15:0] d, input logic c, input logic x);
        int eg;
        clear_log();
        ticks(g);
        eg = exp_gap;
        send(ch, d, c, x);
        exp_gap = 0;
        idle(5);
        chk({r, " count"}, log_a.size(), 3);
        check_pair(r, 0, ch, d, c, x, eg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; start_cmd = 0; reset_cmd = 0; gap_tick = 0;
        a_vld = 0; a_cmd = 0; a_bad = 0; a_word = '0;
        b_vld = 0; b_cmd = 0; b_bad = 0; b_word = '0;
        idle(3);
        rst_n = 1;
        idle(1);

        chk("R8 reset running", running, 0);
        chk("R8 reset we", mem_we, 0);

        // R8: words before start are dropped
        clear_log();
        send(0, 16'hDEAD, 1, 0);
        send(1, 16'hBEEF, 0, 1);
        idle(5);
        chk("R8 no writes before start", log_a.size(), 0);

        start_cmd = 1;
        @(negedge clk);
        start_cmd = 0;
        exp_gap = 0;
        exp_wp = 16'h0000;
        chk("R8 running after start", running, 1);

        // R3/R4/R5 sweep: every channel/sync/validity combination over small gaps
        for (int g = 0; g < 8; g++) begin
            for (int c = 0; c < 8; c++) begin
                one_word("R3 sweep", g, c[2], 16'(g * 4099 + c * 257), c[1], c[0]);
            end
        end

        // R4: saturation of the gap field
        one_word("R4 gap 254", 254, 0, 16'h1234, 1, 0);
        one_word("R4 gap 255", 255, 1, 16'h5678, 0, 0);
        one_word("R4 gap sat", 300, 0, 16'h9ABC, 0, 1);

        // R7: run past the top of the log to force a wrap
        for (int i = 0; i < 70; i++) begin
            one_word("R7 wrap", i % 6, i[0], 16'(i * 33), i[1], 0);
        end

        // R10: word and tick in the same cycle
        clear_log();
        ticks(3);
        gap_tick = 1; a_vld = 1; a_word = 16'hA5A5; a_cmd = 0; a_bad = 0;
        @(negedge clk);
        gap_tick = 0; a_vld = 0;
        idle(5);
        check_pair("R10 coincident", 0, 0, 16'hA5A5, 0, 0, 3);
        exp_gap = 0;
        one_word("R10 next gap", 2, 1, 16'h5A5A, 1, 0);

        // R9: both channels together
        clear_log();
        ticks(6);
        a_vld = 1; a_word = 16'h1111; a_cmd = 1; a_bad = 0;
        b_vld = 1; b_word = 16'h2222; b_cmd = 0; b_bad = 1;
        @(negedge clk);
        a_vld = 0; b_vld = 0;
        idle(10);
        chk("R9 two pairs", log_a.size(), 6);
        check_pair("R9 A first", 0, 0, 16'h1111, 1, 0, 6);
        check_pair("R9 B second", 3, 1, 16'h2222, 0, 1, 6);
        if (log_c.size() >= 4) chk("R9 B spacing", log_c[3] - log_c[0], 3);
        exp_gap = 0;

        // R8: reset pulse abandons an in-flight word and disarms
        clear_log();
        send(0, 16'hCAFE, 0, 0);
        reset_cmd = 1;
        @(negedge clk);
        reset_cmd = 0;
        send(1, 16'hF00D, 1, 1);
        idle(6);
        chk("R8 no writes after reset", log_a.size(), 0);
        chk("R8 disarmed", running, 0);

        // R7: restart begins at address zero
        start_cmd = 1;
        @(negedge clk);
        start_cmd = 0;
        exp_gap = 0;
        exp_wp = 16'h0000;
        one_word("R7 restart", 1, 0, 16'h0BAD, 0, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule